// File: doc/BRIEF.md
# USB 1.1 Host Controller Register Block

This block is the software-visible register set of a legacy full/low-speed USB host controller. It sits on a 32-byte I/O window and takes byte, word and dword accesses on a 5-bit offset. It stores the command word, a write-one-to-clear status word with a hidden two-bit interrupt-cause register, the interrupt-enable word, an 11-bit frame counter, the 4 KiB-aligned frame-list base and a byte of start-of-frame timing. It also stores one control/status word for each root port, and it combines masked and unmaskable status sources into one level interrupt.

The scheduler side sees a run level, a one-cycle frame-start pulse and a one-cycle controller-reset pulse. It reports completion, short-packet, bus-error, host-system-error and process-error events through single-cycle strobes. Each root port receives attach and detach events with a low-speed flag. Each port raises a one-cycle bus-reset request toward its device when software starts a port reset or a global reset.

A four-state sequencer holds the run/stop behaviour. The states are STOPPED, STARTING, RUNNING and RESETTING. STOPPED goes to STARTING when the run bit is written 1 while it was 0. STARTING lasts one cycle and drives the frame-start pulse, then moves to RUNNING. STARTING or RUNNING goes to STOPPED on a command write with the run bit 0. Any state goes to RESETTING on a command write with either reset bit set. RESETTING lasts one cycle and drives the controller-reset pulse, then moves to STOPPED, or to STARTING if the same cycle starts the controller.

Top module: `usb_hc_csr`

## Requirements
- R1: After `rst`, the registers read as follows:
  - command, status, interrupt enable, frame number and frame-list base read 0;
  - start-of-frame timing reads 64;
  - each port reads 0x0080;
  - `irq_o`, `run_o`, `frame_start_o`, `hc_reset_o` and `bus_reset_o` are 0.
- R2: Reads are combinational and decode on the exact offset and the access size (`acc_size`: 0 byte, 1 word, 2 dword, 3 reserved).
  - Word reads: 0x00 command, 0x02 status, 0x04 interrupt enable, 0x06 frame number. Offsets 0x10–0x1F read port (addr>>1)&7.
  - Dword read: 0x08 returns the frame-list base.
  - Byte read: 0x0C returns the timing byte.
  - Every other word read, including a port index at or above NPORTS, returns 0x0000FF7F. Other dword reads and all size-3 reads return 0xFFFFFFFF. Other byte reads return 0x000000FF.
- R3: Run/stop behaves as follows:
  - A command write with bit 0 = 1 while the stored bit 0 is 0 clears halted (status bit 5). It also raises `run_o` and gives a one-cycle `frame_start_o` in the cycle after the write.
  - A command write with bit 0 = 0 sets halted and drops `run_o`.
  - Without a reset bit, the written word is stored.
- R4: A command write with bit 1 (controller reset) or bit 2 (global reset) does the following:
  - It returns every register to its R1 value, and the written command is not stored.
  - It drives a one-cycle `hc_reset_o` and drops `run_o`.
  - A port with a device attached reloads as 0x0083, or 0x0183 if the device is low speed.
  - Bit 2 alone also drives `bus_reset_o` for every attached port in the cycle after the write.
- R5: A word write to status clears each status bit written as 1. Writing bit 0 as 1 also clears both hidden cause bits.
- R6: The hardware strobes set status bits as follows:
  - `cause_set_i[0]` or `cause_set_i[1]` sets the matching cause bit and status bit 0.
  - `usberr_set_i`, `hse_set_i` and `perr_set_i` set status bits 1, 3 and 4.
  - A strobe wins over a clearing write in the same cycle.
- R7: `irq_o` is 1 when any of these holds:
  - cause bit 0 is set with enable bit 2;
  - cause bit 1 is set with enable bit 3;
  - status bit 1 is set with enable bit 0;
  - status bit 2 is set with enable bit 1;
  - status bit 3 is set;
  - status bit 4 is set.
- R8: A word write to 0x06 updates the frame number only while halted is set, and keeps only the low 11 bits.
- R9: A dword write to 0x08 stores bits 31:12. The low 12 bits read as zero.
- R10: A word write to a port keeps the bits in 0x01FB and takes the other bits from the written data. Bits 1 and 3 are then cleared where written as 1.
- R11: A port write that takes bit 9 from 0 to 1 with a device attached drives that port's `bus_reset_o` for one cycle after the write. Without a device, no request is made.
- R12: Attach sets port bits 0 and 1 and sets bit 8 to the low-speed flag. Detach clears bit 0 and sets bit 1 if bit 0 was set. If bit 2 was set, detach also clears it and sets bit 3. Attach to an occupied port applies detach first.
- R13: An attach or detach while command bit 3 is set sets command bit 4 and status bit 2.
- R14: The timing byte is written only by a byte write to 0x0C. The frame-list base is written only by a dword write to 0x08. The word registers are written only by word writes. A write of any other size or offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the current access |
| addr | input | 5 | Byte offset in the window |
| acc_size | input | 2 | Access size: 0 byte, 1 word, 2 dword |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr/acc_size |
| attach_i | input | NPORTS | Device attach event per port |
| detach_i | input | NPORTS | Device detach event per port |
| lowspeed_i | input | NPORTS | Low-speed flag sampled with attach |
| cause_set_i | input | 2 | Completion (0) and short-packet (1) strobes |
| usberr_set_i | input | 1 | Bus error strobe |
| hse_set_i | input | 1 | Host system error strobe |
| perr_set_i | input | 1 | Process error strobe |
| irq_o | output | 1 | Level interrupt |
| run_o | output | 1 | Controller running |
| frame_start_o | output | 1 | One-cycle start of frame processing |
| hc_reset_o | output | 1 | One-cycle controller reset pulse |
| bus_reset_o | output | NPORTS | One-cycle bus reset request per port |

## Verification
The assertions assume that no attach, detach or hardware strobe arrives in the same cycle as a command write carrying a reset bit, because such events are dropped on that edge. The bench keeps events and resets in separate transactions. It also gives each write its own cycle, so a port write and an event for that port never coincide. Attach and detach are issued only at clock-low phases with the low-speed flag held alongside them, so the flag is always valid when a port samples it.

// File: rtl/usb_hc_csr_pkg.sv
package usb_hc_csr_pkg;

    typedef enum logic [1:0] {
        ACC_BYTE  = 2'd0,
        ACC_WORD  = 2'd1,
        ACC_DWORD = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        CS_STOPPED   = 2'd0,
        CS_STARTING  = 2'd1,
        CS_RUNNING   = 2'd2,
        CS_RESETTING = 2'd3
    } ctl_state_e;

    localparam logic [4:0] OFS_CMD = 5'h00;
    localparam logic [4:0] OFS_STS = 5'h02;
    localparam logic [4:0] OFS_IEN = 5'h04;
    localparam logic [4:0] OFS_FRM = 5'h06;
    localparam logic [4:0] OFS_FLB = 5'h08;
    localparam logic [4:0] OFS_SOF = 5'h0C;

    localparam int CMD_RUN    = 0;
    localparam int CMD_HCRST  = 1;
    localparam int CMD_GRST   = 2;
    localparam int CMD_SUSP   = 3;
    localparam int CMD_RESUME = 4;

    localparam int SB_INT  = 0;
    localparam int SB_ERR  = 1;
    localparam int SB_RD   = 2;
    localparam int SB_HSE  = 3;
    localparam int SB_PERR = 4;
    localparam int SB_HALT = 5;
    localparam int STS_W   = 6;

    localparam int PB_CONN    = 0;
    localparam int PB_CONNCHG = 1;
    localparam int PB_EN      = 2;
    localparam int PB_ENCHG   = 3;
    localparam int PB_LS      = 8;
    localparam int PB_RST     = 9;

    localparam logic [15:0] PORT_KEEP_MASK = 16'h01FB;
    localparam logic [15:0] PORT_W1C_MASK  = 16'h000A;
    localparam logic [15:0] PORT_INIT      = 16'h0080;
    localparam logic [15:0] WORD_UNMAPPED  = 16'hFF7F;

endpackage

// File: rtl/usb_hc_cmd_seq.sv
module usb_hc_cmd_seq
    import usb_hc_csr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_wr,
    input  logic [15:0] wdata,
    input  logic        wake_evt,
    output logic [15:0] cmd_q,
    output logic        soft_rst,
    output logic        glob_rst,
    output logic        halt_set,
    output logic        halt_clr,
    output logic        resume_hit,
    output logic        run_o,
    output logic        frame_start_o,
    output logic        hc_reset_o
);

    ctl_state_e  state_q, state_d;
    logic [15:0] cmd_d;
    logic        run_rise, stop_req;

    always_comb begin
        soft_rst   = cmd_wr && (wdata[CMD_HCRST] || wdata[CMD_GRST]);
        glob_rst   = cmd_wr && wdata[CMD_GRST];
        run_rise   = cmd_wr && wdata[CMD_RUN] && !cmd_q[CMD_RUN] && !soft_rst;
        stop_req   = cmd_wr && !wdata[CMD_RUN] && !soft_rst;
        halt_clr   = run_rise;
        halt_set   = stop_req;
        resume_hit = wake_evt && cmd_q[CMD_SUSP] && !soft_rst;
        cmd_d      = cmd_q;
        if (soft_rst) begin
            cmd_d = '0;
        end else begin
            if (cmd_wr) cmd_d = wdata;
            if (resume_hit) cmd_d[CMD_RESUME] = 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_STOPPED, CS_RESETTING: state_d = run_rise ? CS_STARTING : CS_STOPPED;
            CS_STARTING, CS_RUNNING:  state_d = stop_req ? CS_STOPPED : CS_RUNNING;
        endcase
        if (soft_rst) state_d = CS_RESETTING;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CS_STOPPED;
            cmd_q   <= '0;
        end else begin
            state_q <= state_d;
            cmd_q   <= cmd_d;
        end
    end

    always_comb begin
        run_o         = (state_q == CS_STARTING) || (state_q == CS_RUNNING);
        frame_start_o = (state_q == CS_STARTING);
        hc_reset_o    = (state_q == CS_RESETTING);
    end

    a_r3_start_pulse: assert property (@(posedge clk) disable iff (rst)
        halt_clr |=> (frame_start_o && run_o));

    a_r3_stop_drops_run: assert property (@(posedge clk) disable iff (rst)
        halt_set |=> !run_o);

    a_r4_reset_pulse: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (hc_reset_o && !run_o && cmd_q == 16'h0000));

    a_r13_resume_flag: assert property (@(posedge clk) disable iff (rst)
        resume_hit |=> cmd_q[CMD_RESUME]);

endmodule

// File: rtl/usb_hc_status.sv
module usb_hc_status
    import usb_hc_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              sts_wr,
    input  logic              ien_wr,
    input  logic [15:0]       wdata,
    input  logic              halt_set,
    input  logic              halt_clr,
    input  logic              resume_hit,
    input  logic [1:0]        cause_set,
    input  logic              usberr_set,
    input  logic              hse_set,
    input  logic              perr_set,
    output logic [STS_W-1:0]  status_q,
    output logic [15:0]       ien_q,
    output logic              irq_o
);

    logic [STS_W-1:0] status_d;
    logic [1:0]       cause_q, cause_d;
    logic [15:0]      ien_d;

    always_comb begin
        status_d = status_q;
        cause_d  = cause_q;
        ien_d    = ien_q;
        if (soft_rst) begin
            status_d = '0;
            cause_d  = '0;
            ien_d    = '0;
        end else begin
            if (sts_wr) begin
                status_d = status_d & ~wdata[STS_W-1:0];
                if (wdata[SB_INT]) cause_d = '0;
            end
            if (halt_set) status_d[SB_HALT] = 1'b1;
            if (halt_clr) status_d[SB_HALT] = 1'b0;
            if (ien_wr)   ien_d = wdata;
            cause_d = cause_d | cause_set;
            if (|cause_set) status_d[SB_INT]  = 1'b1;
            if (usberr_set) status_d[SB_ERR]  = 1'b1;
            if (hse_set)    status_d[SB_HSE]  = 1'b1;
            if (perr_set)   status_d[SB_PERR] = 1'b1;
            if (resume_hit) status_d[SB_RD]   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            cause_q  <= '0;
            ien_q    <= '0;
        end else begin
            status_q <= status_d;
            cause_q  <= cause_d;
            ien_q    <= ien_d;
        end
    end

    always_comb begin
        irq_o = (cause_q[0] && ien_q[2]) ||
                (cause_q[1] && ien_q[3]) ||
                (status_q[SB_ERR] && ien_q[0]) ||
                (status_q[SB_RD] && ien_q[1]) ||
                status_q[SB_HSE] || status_q[SB_PERR];
    end

    a_r5_w1c_error: assert property (@(posedge clk) disable iff (rst)
        (sts_wr && wdata[SB_ERR] && !usberr_set && !soft_rst) |=> !status_q[SB_ERR]);

    a_r6_cause_sets_int: assert property (@(posedge clk) disable iff (rst)
        ((|cause_set) && !soft_rst) |=> status_q[SB_INT]);

    a_r7_unmasked_hse: assert property (@(posedge clk) disable iff (rst)
        (hse_set && !soft_rst) |=> irq_o);

    a_r7_unmasked_perr: assert property (@(posedge clk) disable iff (rst)
        (perr_set && !soft_rst) |=> irq_o);

endmodule

// File: rtl/usb_hc_port.sv
module usb_hc_port
    import usb_hc_csr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        soft_rst,
    input  logic        glob_rst,
    input  logic        port_wr,
    input  logic [15:0] wdata,
    input  logic        attach_i,
    input  logic        detach_i,
    input  logic        lowspeed_i,
    output logic [15:0] ctrl_q,
    output logic        bus_reset_o
);

    logic [15:0] ctrl_d;
    logic        attached_q, attached_d;
    logic        ls_q, ls_d;
    logic        bus_d;

    always_comb begin
        ctrl_d     = ctrl_q;
        attached_d = attached_q;
        ls_d       = ls_q;
        bus_d      = 1'b0;
        if (soft_rst) begin
            ctrl_d = PORT_INIT;
            if (attached_q) begin
                ctrl_d[PB_CONN]    = 1'b1;
                ctrl_d[PB_CONNCHG] = 1'b1;
                ctrl_d[PB_LS]      = ls_q;
            end
            bus_d = glob_rst && attached_q;
        end else begin
            if (port_wr) begin
                ctrl_d = (ctrl_q & PORT_KEEP_MASK) | (wdata & ~PORT_KEEP_MASK);
                ctrl_d = ctrl_d & ~(wdata & PORT_W1C_MASK);
                bus_d  = attached_q && wdata[PB_RST] && !ctrl_q[PB_RST];
            end
            if (detach_i || (attach_i && attached_q)) begin
                if (ctrl_d[PB_CONN]) begin
                    ctrl_d[PB_CONN]    = 1'b0;
                    ctrl_d[PB_CONNCHG] = 1'b1;
                end
                if (ctrl_d[PB_EN]) begin
                    ctrl_d[PB_EN]    = 1'b0;
                    ctrl_d[PB_ENCHG] = 1'b1;
                end
                attached_d = 1'b0;
            end
            if (attach_i) begin
                ctrl_d[PB_CONN]    = 1'b1;
                ctrl_d[PB_CONNCHG] = 1'b1;
                ctrl_d[PB_LS]      = lowspeed_i;
                attached_d         = 1'b1;
                ls_d               = lowspeed_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q      <= PORT_INIT;
            attached_q  <= 1'b0;
            ls_q        <= 1'b0;
            bus_reset_o <= 1'b0;
        end else begin
            ctrl_q      <= ctrl_d;
            attached_q  <= attached_d;
            ls_q        <= ls_d;
            bus_reset_o <= bus_d;
        end
    end

    a_r11_needs_device: assert property (@(posedge clk) disable iff (rst)
        bus_reset_o |-> $past(attached_q));

    a_r12_attach_flags: assert property (@(posedge clk) disable iff (rst)
        (attach_i && !soft_rst) |=> (ctrl_q[PB_CONN] && ctrl_q[PB_CONNCHG]));

    a_r10_speed_kept: assert property (@(posedge clk) disable iff (rst)
        (port_wr && !attach_i && !detach_i && !soft_rst) |=> (ctrl_q[PB_LS] == $past(ctrl_q[PB_LS])));

endmodule

// File: rtl/usb_hc_csr.sv
module usb_hc_csr
    import usb_hc_csr_pkg::*;
#(
    parameter int NPORTS   = 2,
    parameter int FRNUM_W  = 11,
    parameter int FLB_LSB  = 12,
    parameter int SOF_W    = 8,
    parameter int SOF_INIT = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [4:0]        addr,
    input  logic [1:0]        acc_size,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [NPORTS-1:0] attach_i,
    input  logic [NPORTS-1:0] detach_i,
    input  logic [NPORTS-1:0] lowspeed_i,
    input  logic [1:0]        cause_set_i,
    input  logic              usberr_set_i,
    input  logic              hse_set_i,
    input  logic              perr_set_i,
    output logic              irq_o,
    output logic              run_o,
    output logic              frame_start_o,
    output logic              hc_reset_o,
    output logic [NPORTS-1:0] bus_reset_o
);

    localparam int FLB_W = 32 - FLB_LSB;
    localparam logic [SOF_W-1:0] SOF_RST = SOF_W'(SOF_INIT);

    acc_size_e acc;
    logic is_byte, is_word, is_dword;
    logic cmd_wr, sts_wr, ien_wr, frm_wr, flb_wr, sof_wr;
    logic [NPORTS-1:0] port_wr;
    logic [2:0] port_sel;
    logic wake_evt;

    logic [15:0]        cmd_q, ien_q;
    logic [STS_W-1:0]   status_q;
    logic               soft_rst, glob_rst, halt_set, halt_clr, resume_hit;
    logic [FRNUM_W-1:0] frnum_q;
    logic [FLB_W-1:0]   flb_q;
    logic [SOF_W-1:0]   sof_q;
    logic [NPORTS-1:0][15:0] port_ctrl;
    logic [15:0] word_rd;

    assign acc      = acc_size_e'(acc_size);
    assign is_byte  = (acc == ACC_BYTE);
    assign is_word  = (acc == ACC_WORD);
    assign is_dword = (acc == ACC_DWORD);
    assign port_sel = addr[3:1];
    assign wake_evt = |(attach_i | detach_i);

    always_comb begin
        cmd_wr = wr_en && is_word && (addr == OFS_CMD);
        sts_wr = wr_en && is_word && (addr == OFS_STS);
        ien_wr = wr_en && is_word && (addr == OFS_IEN);
        frm_wr = wr_en && is_word && (addr == OFS_FRM);
        flb_wr = wr_en && is_dword && (addr == OFS_FLB);
        sof_wr = wr_en && is_byte && (addr == OFS_SOF);
        for (int p = 0; p < NPORTS; p++) begin
            port_wr[p] = wr_en && is_word && addr[4] && (port_sel == 3'(p));
        end
    end

    usb_hc_cmd_seq u_cmd (
        .clk           (clk),
        .rst           (rst),
        .cmd_wr        (cmd_wr),
        .wdata         (wdata[15:0]),
        .wake_evt      (wake_evt),
        .cmd_q         (cmd_q),
        .soft_rst      (soft_rst),
        .glob_rst      (glob_rst),
        .halt_set      (halt_set),
        .halt_clr      (halt_clr),
        .resume_hit    (resume_hit),
        .run_o         (run_o),
        .frame_start_o (frame_start_o),
        .hc_reset_o    (hc_reset_o)
    );

    usb_hc_status u_sts (
        .clk        (clk),
        .rst        (rst),
        .soft_rst   (soft_rst),
        .sts_wr     (sts_wr),
        .ien_wr     (ien_wr),
        .wdata      (wdata[15:0]),
        .halt_set   (halt_set),
        .halt_clr   (halt_clr),
        .resume_hit (resume_hit),
        .cause_set  (cause_set_i),
        .usberr_set (usberr_set_i),
        .hse_set    (hse_set_i),
        .perr_set   (perr_set_i),
        .status_q   (status_q),
        .ien_q      (ien_q),
        .irq_o      (irq_o)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        usb_hc_port u_port (
            .clk         (clk),
            .rst         (rst),
            .soft_rst    (soft_rst),
            .glob_rst    (glob_rst),
            .port_wr     (port_wr[p]),
            .wdata       (wdata[15:0]),
            .attach_i    (attach_i[p]),
            .detach_i    (detach_i[p]),
            .lowspeed_i  (lowspeed_i[p]),
            .ctrl_q      (port_ctrl[p]),
            .bus_reset_o (bus_reset_o[p])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            frnum_q <= '0;
            flb_q   <= '0;
            sof_q   <= SOF_RST;
        end else begin
            if (frm_wr && status_q[SB_HALT]) frnum_q <= wdata[FRNUM_W-1:0];
            if (flb_wr) flb_q <= wdata[31:FLB_LSB];
            if (sof_wr) sof_q <= wdata[SOF_W-1:0];
        end
    end

    always_comb begin
        word_rd = WORD_UNMAPPED;
        if (addr == OFS_CMD)      word_rd = cmd_q;
        else if (addr == OFS_STS) word_rd = 16'(status_q);
        else if (addr == OFS_IEN) word_rd = ien_q;
        else if (addr == OFS_FRM) word_rd = 16'(frnum_q);
        else if (addr[4]) begin
            for (int p = 0; p < NPORTS; p++) begin
                if (port_sel == 3'(p)) word_rd = port_ctrl[p];
            end
        end
    end

    always_comb begin
        unique case (acc)
            ACC_BYTE:  rdata = (addr == OFS_SOF) ? 32'(sof_q) : 32'h0000_00FF;
            ACC_WORD:  rdata = {16'h0000, word_rd};
            ACC_DWORD: rdata = (addr == OFS_FLB) ? {flb_q, {FLB_LSB{1'b0}}} : 32'hFFFF_FFFF;
            ACC_RSVD:  rdata = 32'hFFFF_FFFF;
        endcase
    end

    a_r8_frnum_locked: assert property (@(posedge clk) disable iff (rst)
        (frm_wr && !status_q[SB_HALT] && !soft_rst) |=> $stable(frnum_q));

    a_r4_frnum_cleared: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (frnum_q == '0 && sof_q == SOF_RST));

    a_r14_sof_only_byte: assert property (@(posedge clk) disable iff (rst)
        (!sof_wr && !soft_rst) |=> $stable(sof_q));

endmodule

// File: tb/usb_hc_csr_tb_top.sv
module usb_hc_csr_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [4:0]  addr;
    logic [1:0]  acc_size;
    logic [31:0] wdata, rdata;
    logic [1:0]  attach, detach, lowspeed, cause_set, bus_rst;
    logic        usberr, hse, perr, irq, run, fstart, hcrst;

    int total = 0;
    int fails = 0;
    bit done = 0;

    usb_hc_csr dut_i (
        .clk (clk), .rst (rst), .wr_en (wr_en), .addr (addr), .acc_size (acc_size),
        .wdata (wdata), .rdata (rdata), .attach_i (attach), .detach_i (detach),
        .lowspeed_i (lowspeed), .cause_set_i (cause_set), .usberr_set_i (usberr),
        .hse_set_i (hse), .perr_set_i (perr), .irq_o (irq), .run_o (run),
        .frame_start_o (fstart), .hc_reset_o (hcrst), .bus_reset_o (bus_rst)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [1:0] sz, input logic [31:0] d);
        addr = a; acc_size = sz; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [1:0] sz, output logic [31:0] v);
        addr = a; acc_size = sz;
        #1 v = rdata;
    endtask

    task automatic evt(input logic [1:0] att, input logic [1:0] det, input logic [1:0] ls);
        attach = att; detach = det; lowspeed = ls;
        @(negedge clk);
        attach = '0; detach = '0; lowspeed = '0;
    endtask

    task automatic strobe(input int which);
        case (which)
            0: cause_set = 2'b01;
            1: cause_set = 2'b10;
            2: usberr = 1'b1;
            3: hse = 1'b1;
            default: perr = 1'b1;
        endcase
        @(negedge clk);
        cause_set = '0; usberr = 0; hse = 0; perr = 0;
    endtask

    function automatic logic [31:0] reset_view(input int a, input int sz);
        if (sz == 0) return (a == 12) ? 32'd64 : 32'h0000_00FF;
        if (sz == 2) return (a == 8) ? 32'h0 : 32'hFFFF_FFFF;
        if (sz == 3) return 32'hFFFF_FFFF;
        if (a == 0 || a == 2 || a == 4 || a == 6) return 32'h0;
        if (a >= 16 && ((a >> 1) & 7) < 2) return 32'h0000_0080;
        return 32'h0000_FF7F;
    endfunction

    function automatic logic [15:0] port_merge(input logic [15:0] old, input logic [15:0] w);
        return ((old & 16'h01FB) | (w & 16'hFE04)) & ~(w & 16'h000A);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; total++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [15:0] p1;
        logic [15:0] pats [7];
        rst = 1; wr_en = 0; addr = 0; acc_size = 1; wdata = 0;
        attach = 0; detach = 0; lowspeed = 0; cause_set = 0; usberr = 0; hse = 0; perr = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state and R2 decode sweep
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 run", {31'b0, run}, 0);
        chk("R1 pulses", {28'b0, fstart, hcrst, bus_rst}, 0);
        for (int a = 0; a < 32; a++) begin
            for (int sz = 0; sz < 4; sz++) begin
                rd(5'(a), 2'(sz), v);
                chk($sformatf("R2 read a=%0h sz=%0d", a, sz), v, reset_view(a, sz));
            end
        end

        // R14 size-qualified writes
        wr(5'h0C, 2'd0, 32'h5A);
        rd(5'h0C, 2'd0, v); chk("R14 sof byte", v, 32'h5A);
        wr(5'h0C, 2'd1, 32'h1234);
        rd(5'h0C, 2'd0, v); chk("R14 sof word ignored", v, 32'h5A);
        wr(5'h00, 2'd2, 32'h0000_0009);
        rd(5'h00, 2'd1, v); chk("R14 cmd dword ignored", v, 0);
        wr(5'h08, 2'd1, 32'hFFFF);
        rd(5'h08, 2'd2, v); chk("R14 flb word ignored", v, 0);

        // R9 frame-list base
        for (int i = 0; i < 4; i++) begin
            logic [31:0] d;
            d = 32'hDEAD_BEEF ^ (32'h1357_9BDF * i);
            wr(5'h08, 2'd2, d);
            rd(5'h08, 2'd2, v); chk("R9 flb", v, d & 32'hFFFF_F000);
        end

        // R8 frame number locked until halted
        wr(5'h06, 2'd1, 32'h0123);
        rd(5'h06, 2'd1, v); chk("R8 frnum locked", v, 0);
        wr(5'h00, 2'd1, 32'h0000);
        rd(5'h02, 2'd1, v); chk("R3 halted set", v, 32'h20);
        wr(5'h06, 2'd1, 32'hFFFF);
        rd(5'h06, 2'd1, v); chk("R8 frnum 11 bits", v, 32'h07FF);

        // R3 run/stop
        wr(5'h00, 2'd1, 32'h0001);
        chk("R3 frame_start", {31'b0, fstart}, 1);
        chk("R3 run", {31'b0, run}, 1);
        rd(5'h02, 2'd1, v); chk("R3 halted cleared", v, 0);
        rd(5'h00, 2'd1, v); chk("R3 cmd stored", v, 1);
        @(negedge clk);
        chk("R3 frame_start one cycle", {31'b0, fstart}, 0);
        chk("R3 still running", {31'b0, run}, 1);
        wr(5'h06, 2'd1, 32'h0055);
        rd(5'h06, 2'd1, v); chk("R8 frnum locked while running", v, 32'h07FF);
        wr(5'h00, 2'd1, 32'h0001);
        chk("R3 no restart pulse", {31'b0, fstart}, 0);
        wr(5'h00, 2'd1, 32'h0000);
        chk("R3 stopped", {31'b0, run}, 0);
        rd(5'h02, 2'd1, v); chk("R3 halted again", v, 32'h20);

        // R5 R6 R7 interrupt sweep
        for (int src = 0; src < 5; src++) begin
            for (int ie = 0; ie < 16; ie++) begin
                logic expi;
                logic [31:0] exps;
                wr(5'h02, 2'd1, 32'h003F);
                wr(5'h04, 2'd1, 32'(ie));
                strobe(src);
                case (src)
                    0: begin expi = ie[2]; exps = 32'h01; end
                    1: begin expi = ie[3]; exps = 32'h01; end
                    2: begin expi = ie[0]; exps = 32'h02; end
                    3: begin expi = 1'b1;  exps = 32'h08; end
                    default: begin expi = 1'b1; exps = 32'h10; end
                endcase
                chk($sformatf("R7 irq src=%0d ie=%0h", src, ie), {31'b0, irq}, {31'b0, expi});
                rd(5'h02, 2'd1, v);
                chk($sformatf("R6 status src=%0d", src), v, exps);
                wr(5'h02, 2'd1, 32'h003F);
                chk($sformatf("R5 irq cleared src=%0d", src), {31'b0, irq}, 0);
            end
        end
        rd(5'h04, 2'd1, v); chk("R7 enable readback", v, 32'h000F);

        // R5 cause cleared only through bit 0
        wr(5'h04, 2'd1, 32'h000C);
        strobe(0); strobe(1);
        chk("R7 both causes", {31'b0, irq}, 1);
        wr(5'h02, 2'd1, 32'h0002);
        chk("R5 cause kept", {31'b0, irq}, 1);
        wr(5'h02, 2'd1, 32'h0001);
        chk("R5 cause cleared", {31'b0, irq}, 0);
        rd(5'h02, 2'd1, v); chk("R5 usbint cleared", v, 0);

        // R6 strobe wins over clear
        addr = 5'h02; acc_size = 2'd1; wdata = 32'h0002; wr_en = 1; usberr = 1;
        @(negedge clk);
        wr_en = 0; usberr = 0;
        rd(5'h02, 2'd1, v); chk("R6 set wins", v, 32'h02);
        wr(5'h02, 2'd1, 32'h003F);

        // R10 port merge sweep on port 1 (no device), R11 no device no reset
        pats = '{16'hFFFF, 16'h0000, 16'h0204, 16'hA5A5, 16'h5A5A, 16'h000A, 16'h0004};
        p1 = 16'h0080;
        for (int i = 0; i < 7; i++) begin
            wr(5'h12, 2'd1, {16'h0, pats[i]});
            chk("R11 no device", {30'b0, bus_rst}, 0);
            p1 = port_merge(p1, pats[i]);
            rd(5'h13, 2'd1, v); chk($sformatf("R10 port1 w=%h", pats[i]), v, {16'h0, p1});
        end
        wr(5'h1A, 2'd1, 32'hFFFF);
        rd(5'h1A, 2'd1, v); chk("R2 absent port", v, 32'hFF7F);
        rd(5'h10, 2'd1, v); chk("R10 port0 untouched", v, 32'h0080);
        rd(5'h12, 2'd1, v); chk("R10 port1 untouched", v, {16'h0, p1});

        // R12 attach, R10 w1c, R11 bus reset
        evt(2'b01, 2'b00, 2'b00);
        rd(5'h10, 2'd1, v); chk("R12 attach full", v, 32'h0083);
        wr(5'h10, 2'd1, 32'h0002);
        rd(5'h10, 2'd1, v); chk("R10 clear connect change", v, 32'h0081);
        wr(5'h10, 2'd1, 32'h0004);
        rd(5'h10, 2'd1, v); chk("R10 enable", v, 32'h0085);
        wr(5'h10, 2'd1, 32'h0204);
        chk("R11 bus reset", {30'b0, bus_rst}, 32'h1);
        @(negedge clk);
        chk("R11 one cycle", {30'b0, bus_rst}, 0);
        wr(5'h10, 2'd1, 32'h0204);
        chk("R11 no repeat", {30'b0, bus_rst}, 0);
        evt(2'b00, 2'b01, 2'b00);
        rd(5'h10, 2'd1, v); chk("R12 detach enabled", v, 32'h028A);
        evt(2'b10, 2'b00, 2'b10);
        p1 = p1 | 16'h0103;
        rd(5'h12, 2'd1, v); chk("R12 attach low", v, {16'h0, p1});
        rd(5'h02, 2'd1, v); chk("R13 no resume without suspend", v, 0);

        // R13 resume on event while suspended
        wr(5'h00, 2'd1, 32'h0008);
        evt(2'b00, 2'b10, 2'b00);
        if (p1[0]) begin p1[0] = 0; p1[1] = 1; end
        if (p1[2]) begin p1[2] = 0; p1[3] = 1; end
        rd(5'h12, 2'd1, v); chk("R12 detach port1", v, {16'h0, p1});
        rd(5'h00, 2'd1, v); chk("R13 resume flag", v, 32'h0018);
        rd(5'h02, 2'd1, v); chk("R13 resume status", v, 32'h0024);
        chk("R7 resume masked", {31'b0, irq}, 0);
        wr(5'h04, 2'd1, 32'h0002);
        chk("R7 resume irq", {31'b0, irq}, 1);

        // R4 controller reset
        evt(2'b01, 2'b00, 2'b01);
        rd(5'h10, 2'd1, v); chk("R12 reattach low", v, 32'h038B);
        wr(5'h0C, 2'd0, 32'h11);
        wr(5'h00, 2'd1, 32'h0002);
        chk("R4 hc_reset pulse", {31'b0, hcrst}, 1);
        chk("R4 no bus reset", {30'b0, bus_rst}, 0);
        rd(5'h00, 2'd1, v); chk("R4 cmd cleared", v, 0);
        rd(5'h02, 2'd1, v); chk("R4 status cleared", v, 0);
        rd(5'h04, 2'd1, v); chk("R4 enable cleared", v, 0);
        rd(5'h06, 2'd1, v); chk("R4 frnum cleared", v, 0);
        rd(5'h08, 2'd2, v); chk("R4 flb cleared", v, 0);
        rd(5'h0C, 2'd0, v); chk("R4 sof reload", v, 64);
        rd(5'h10, 2'd1, v); chk("R4 port0 attached", v, 32'h0183);
        rd(5'h12, 2'd1, v); chk("R4 port1 empty", v, 32'h0080);
        chk("R4 irq low", {31'b0, irq}, 0);
        @(negedge clk);
        chk("R4 pulse one cycle", {31'b0, hcrst}, 0);

        // R4 global reset beats a start
        wr(5'h00, 2'd1, 32'h0001);
        chk("R3 run before reset", {31'b0, run}, 1);
        wr(5'h00, 2'd1, 32'h0005);
        chk("R4 global hc_reset", {31'b0, hcrst}, 1);
        chk("R4 global bus reset", {30'b0, bus_rst}, 32'h1);
        chk("R4 run dropped", {31'b0, run}, 0);
        chk("R4 no frame start", {31'b0, fstart}, 0);
        rd(5'h00, 2'd1, v); chk("R4 global cmd", v, 0);
        @(negedge clk);
        chk("R4 global pulses end", {29'b0, hcrst, bus_rst}, 0);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule